// File: doc/BRIEF.md
# Dual-Framing Serial Register Port Master

This block is the host end of a four-wire register port: an enable strobe, a serial clock, a data-out line toward the slave and a data-in line back from it. On a one-cycle start request it takes a framing choice, a read/write flag, a register address, a chip address and 24 bits of write data. It runs the whole transaction on the wires, then returns the 24-bit read data with a one-cycle done pulse. The serial clock comes from the system clock: each half-period is a parameterised number of system clocks.

Two framings share the same wires, and the slave tells them apart by which line rises first. In address-first framing the enable rises before any clock edge, and the command and address lead the frame. In open framing the enable stays low while the 32 clocks run, data leads, register and chip address trail, and a short enable pulse afterwards makes the slave latch the word. A read in open framing needs two frames, and the block runs both on its own. The first frame writes the wanted register number into a pointer field of register zero. The second clocks the register contents back.

All waits are whole numbers of system clocks set by parameters: enable-to-clock setup, the gap from the last clock to the enable change, the latch-pulse width and the recovery time with the enable low. Each wait is raised to at least one serial-clock half-period.

Top module: `sreg_port_master`

## Requirements
- R1: While reset is high and after it is released, sen, sclk, sdi, busy and done are 0 and sdi_oe is 1.
- R2: Address-first frame (open_mode=0): sen rises at least SETUP_CYC system clocks before the first sclk rising edge and stays high through all 32 rising edges. Edge 1 carries the read flag (1 = read, 0 = write). Edges 2 to 7 carry reg_addr[5:0], most significant bit first.
- R3: Address-first write: edges 8 to 31 carry wdata[23:0] MSB first, and edge 32 carries 0. There are exactly 32 rising edges, after which sen falls.
- R4: Address-first read: sdi_oe is 0 from the falling edge of clock 7 until the frame ends, and sdi is 0 on edges 8 to 32. Bits are taken from sdo at the falling edges of clocks 8 to 31, MSB first, and appear on rdata[23:0] when done pulses.
- R5: Open write (open_mode=1, rd=0): sen is low during all 32 rising edges. Those edges carry wdata[23:0], then reg_addr[4:0], then chip_addr[2:0], each MSB first. After edge 32, sen is high for at least SENHI_CYC system clocks, and the slave latches the word on that rising edge of sen.
- R6: Open read (open_mode=1, rd=1) is two open frames. The first is a write to register 0 whose 24-bit data has bits [7:3] equal to reg_addr[4:0] and all other bits 0, with chip field chip_addr. The second sends 0 on all 32 edges and takes rdata from sdo at the falling edges of clocks 1 to 24, MSB first.
- R7: Every sclk high phase lasts HALF_DIV system clocks, and sdi never changes while sclk is high.
- R8: After each frame, sen stays low for at least RECOV_CYC system clocks before done or the next frame.
- R9: busy is 1 from the cycle after an accepted start until done, which is a single-cycle pulse with busy 0. A start while busy is ignored: it causes no frame and does not change the transaction in flight.
- R10: A write transaction leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transaction request, accepted when idle |
| open_mode | input | 1 | 0 = address-first framing, 1 = open framing |
| rd | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 6 | Register address (open framing uses bits 4:0) |
| chip_addr | input | 3 | Chip address for open framing |
| wdata | input | 24 | Write data |
| sdo | input | 1 | Serial data from the slave |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Last read result |
| sen | output | 1 | Serial enable strobe |
| sclk | output | 1 | Serial clock |
| sdi | output | 1 | Serial data to the slave |
| sdi_oe | output | 1 | Drive enable for sdi, low while the slave answers |

## Verification
The bench builds the block with HALF_DIV=2, SETUP_CYC=3, SENHI_CYC=3 and RECOV_CYC=5. These distinct small values let the bench measure each interval and tell one from another. They also keep a frame near 140 system clocks, so every framing, the two-frame open read and an ignored mid-transaction start all fit in one short run. A bus-level slave model decodes which line rose first and supplies known read data.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int FRAME_LEN = 32;
    localparam int DATA_W    = 24;
    localparam int AF_ADDR_W = 6;
    localparam int OP_REG_W  = 5;
    localparam int CHIP_W    = 3;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef enum logic {
        FM_ADDR_FIRST = 1'b0,
        FM_OPEN       = 1'b1
    } frame_mode_e;

    typedef enum logic [1:0] {
        PH_SINGLE,
        PH_POINTER,
        PH_FETCH
    } op_phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_PULSE,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        frame_mode_e            mode;
        logic                   rd;
        logic [AF_ADDR_W-1:0]   reg_addr;
        logic [CHIP_W-1:0]      chip;
        logic [DATA_W-1:0]      wdata;
    } xfer_req_t;

    typedef struct packed {
        logic sen;
        logic sclk;
        logic sdi_oe;
    } pin_ctl_t;

    function automatic int unsigned at_least(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Serial word for one frame, first transmitted bit in the MSB.
    function automatic logic [FRAME_LEN-1:0] frame_word(xfer_req_t r, op_phase_e ph);
        logic [FRAME_LEN-1:0] w;
        if (r.mode == FM_ADDR_FIRST) begin
            w = {r.rd, r.reg_addr, (r.rd ? {DATA_W{1'b0}} : r.wdata), 1'b0};
        end else begin
            case (ph)
                PH_POINTER: w = {{(DATA_W-8){1'b0}}, r.reg_addr[OP_REG_W-1:0], 3'b000,
                                 {OP_REG_W{1'b0}}, r.chip};
                PH_FETCH:   w = '0;
                default:    w = {r.wdata, r.reg_addr[OP_REG_W-1:0], r.chip};
            endcase
        end
        return w;
    endfunction

    // Does the falling edge that ends clock (idx+1) sample the return line?
    function automatic logic in_capture(frame_mode_e m, logic rd, op_phase_e ph,
                                        logic [IDX_W-1:0] idx);
        if (m == FM_ADDR_FIRST)
            return rd && (idx >= IDX_W'(7)) && (idx <= IDX_W'(30));
        else
            return (ph == PH_FETCH) && (idx <= IDX_W'(23));
    endfunction

    function automatic pin_ctl_t pin_decode(seq_state_e st, frame_mode_e m, logic rd,
                                            logic [IDX_W-1:0] idx);
        pin_ctl_t p;
        logic     in_frame;
        in_frame = (st == ST_HIGH) || (st == ST_LOW) || (st == ST_TAIL);
        p.sclk   = (st == ST_HIGH);
        if (m == FM_ADDR_FIRST)
            p.sen = in_frame || (st == ST_LEAD);
        else
            p.sen = (st == ST_PULSE);
        p.sdi_oe = !((m == FM_ADDR_FIRST) && rd && in_frame && (idx >= IDX_W'(7)));
        return p;
    endfunction

endpackage

// File: rtl/sreg_timer.sv
module sreg_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
    import sreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] load_word,
    input  logic                 step,
    input  logic                 capture,
    input  logic                 sdo,
    output logic                 sdi,
    output logic [DATA_W-1:0]    rdata
);
    logic [FRAME_LEN-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= '0;
        else if (load)
            tx_q <= load_word;
        else if (step)
            tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= {rdata[DATA_W-2:0], sdo};
    end

    assign sdi = tx_q[FRAME_LEN-1];
endmodule

// File: rtl/sreg_seq.sv
module sreg_seq
    import sreg_pkg::*;
#(
    parameter int HALF_CYC  = 2,
    parameter int SETUP_CYC = 2,
    parameter int SENHI_CYC = 2,
    parameter int RECOV_CYC = 2,
    parameter int CW        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  xfer_req_t            req_in,
    input  logic                 tmr_zero,
    output logic                 tmr_load,
    output logic [CW-1:0]        tmr_val,
    output logic                 sh_load,
    output logic [FRAME_LEN-1:0] sh_word,
    output logic                 sh_step,
    output logic                 sh_capture,
    output pin_ctl_t             pins,
    output logic                 busy,
    output logic                 done
);
    localparam logic [CW-1:0] HALF_V  = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] SENHI_V = CW'(SENHI_CYC - 1);
    localparam logic [CW-1:0] RECOV_V = CW'(RECOV_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    seq_state_e       state, state_n;
    op_phase_e        phase, phase_n;
    xfer_req_t        req_q, req_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             done_n;

    always_comb begin
        state_n    = state;
        phase_n    = phase;
        req_n      = req_q;
        idx_n      = idx;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        sh_step    = 1'b0;
        sh_capture = 1'b0;
        done_n     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    req_n    = req_in;
                    phase_n  = (req_in.mode == FM_OPEN && req_in.rd) ? PH_POINTER : PH_SINGLE;
                    idx_n    = '0;
                    state_n  = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_V;
                    sh_load  = 1'b1;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (tmr_zero) begin
                    state_n  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_V;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    sh_step    = 1'b1;
                    sh_capture = in_capture(req_q.mode, req_q.rd, phase, idx);
                    tmr_load   = 1'b1;
                    tmr_val    = HALF_V;
                    if (idx == LAST_IDX) begin
                        state_n = ST_TAIL;
                    end else begin
                        idx_n   = idx + IDX_W'(1);
                        state_n = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (req_q.mode == FM_ADDR_FIRST) begin
                        state_n = ST_RECOV;
                        tmr_val = RECOV_V;
                    end else begin
                        state_n = ST_PULSE;
                        tmr_val = SENHI_V;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    state_n  = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = RECOV_V;
                end
            end
            ST_RECOV: begin
                if (tmr_zero) begin
                    if (phase == PH_POINTER) begin
                        phase_n  = PH_FETCH;
                        idx_n    = '0;
                        state_n  = ST_LEAD;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_V;
                        sh_load  = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                        done_n  = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        sh_word = frame_word(req_n, phase_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_SINGLE;
            req_q <= '0;
            idx   <= '0;
            pins  <= '{sen: 1'b0, sclk: 1'b0, sdi_oe: 1'b1};
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            req_q <= req_n;
            idx   <= idx_n;
            pins  <= pin_decode(state_n, req_n.mode, req_n.rd, idx_n);
            busy  <= (state_n != ST_IDLE);
            done  <= done_n;
        end
    end

    // R2: address-first clocks only run under a high enable
    a_r2_sen_over_clocks: assert property (@(posedge clk) disable iff (rst)
        (pins.sclk && req_q.mode == FM_ADDR_FIRST) |-> pins.sen);

    // R5: open framing clocks only run under a low enable
    a_r5_sen_low_clocks: assert property (@(posedge clk) disable iff (rst)
        (pins.sclk && req_q.mode == FM_OPEN) |-> !pins.sen);

    // R4: address-first sampling happens with the data line released
    a_r4_released_on_capture: assert property (@(posedge clk) disable iff (rst)
        (sh_capture && req_q.mode == FM_ADDR_FIRST) |-> !pins.sdi_oe);

    // R9: done is one cycle wide
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done closes a busy interval
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9: a request during a transaction does not alter it
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));
endmodule

// File: rtl/sreg_port_master.sv
module sreg_port_master
    import sreg_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int SETUP_CYC = 4,
    parameter int SENHI_CYC = 4,
    parameter int RECOV_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        open_mode,
    input  logic        rd,
    input  logic [5:0]  reg_addr,
    input  logic [2:0]  chip_addr,
    input  logic [23:0] wdata,
    input  logic        sdo,
    output logic        busy,
    output logic        done,
    output logic [23:0] rdata,
    output logic        sen,
    output logic        sclk,
    output logic        sdi,
    output logic        sdi_oe
);
    localparam int HALF_E  = at_least(HALF_DIV, 1);
    localparam int SETUP_E = at_least(SETUP_CYC, HALF_E);
    localparam int SENHI_E = at_least(SENHI_CYC, HALF_E);
    localparam int RECOV_E = at_least(RECOV_CYC, HALF_E);
    localparam int MAX_E   = at_least(at_least(SETUP_E, SENHI_E), RECOV_E);
    localparam int CW      = $clog2(MAX_E + 1);

    xfer_req_t            req;
    logic                 tmr_load, tmr_zero;
    logic [CW-1:0]        tmr_val;
    logic                 sh_load, sh_step, sh_capture;
    logic [FRAME_LEN-1:0] sh_word;
    pin_ctl_t             pins;

    always_comb begin
        req.mode     = open_mode ? FM_OPEN : FM_ADDR_FIRST;
        req.rd       = rd;
        req.reg_addr = reg_addr;
        req.chip     = chip_addr;
        req.wdata    = wdata;
    end

    sreg_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sreg_seq #(
        .HALF_CYC  (HALF_E),
        .SETUP_CYC (SETUP_E),
        .SENHI_CYC (SENHI_E),
        .RECOV_CYC (RECOV_E),
        .CW        (CW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_in     (req),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .sh_load    (sh_load),
        .sh_word    (sh_word),
        .sh_step    (sh_step),
        .sh_capture (sh_capture),
        .pins       (pins),
        .busy       (busy),
        .done       (done)
    );

    sreg_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_word (sh_word),
        .step      (sh_step),
        .capture   (sh_capture),
        .sdo       (sdo),
        .sdi       (sdi),
        .rdata     (rdata)
    );

    assign sen    = pins.sen;
    assign sclk   = pins.sclk;
    assign sdi_oe = pins.sdi_oe;

    // R7: the data line holds still across a high clock phase
    a_r7_sdi_still_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdi));

    // R10: outside a busy interval the read result holds
    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |=> $stable(rdata));
endmodule

// File: tb/sreg_port_master_bench.sv
module sreg_port_master_bench;
    localparam int HALF  = 2;
    localparam int SETUP = 3;
    localparam int SENHI = 3;
    localparam int RECOV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, open_mode = 1'b0, rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [2:0]  chip_addr = '0;
    logic [23:0] wdata = '0;
    logic        sdo = 1'b0;
    logic        busy, done, sen, sclk, sdi, sdi_oe;
    logic [23:0] rdata;

    always #5 clk = ~clk;

    sreg_port_master #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .SENHI_CYC(SENHI),
                       .RECOV_CYC(RECOV)) u_sreg_port_master (
        .clk(clk), .rst(rst), .start(start), .open_mode(open_mode), .rd(rd),
        .reg_addr(reg_addr), .chip_addr(chip_addr), .wdata(wdata), .sdo(sdo),
        .busy(busy), .done(done), .rdata(rdata), .sen(sen), .sclk(sclk),
        .sdi(sdi), .sdi_oe(sdi_oe));

    typedef struct packed {
        logic        open_m;
        logic        rd;
        logic [5:0]  addr;
        logic [2:0]  chip;
        logic [23:0] wdata;
        logic [23:0] sval;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 6'h2A, 3'h0, 24'hA5C3F0, 24'h000000},
        '{1'b0, 1'b1, 6'h15, 3'h0, 24'h000000, 24'h3C5A96},
        '{1'b1, 1'b0, 6'h13, 3'h5, 24'h81FF02, 24'h000000},
        '{1'b1, 1'b1, 6'h0B, 3'h6, 24'h000000, 24'hC30F5A},
        '{1'b0, 1'b0, 6'h3F, 3'h0, 24'hFFFFFF, 24'h000000},
        '{1'b0, 1'b1, 6'h00, 3'h0, 24'h000000, 24'h000001}
    };

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus-level slave model, sampled away from the active edge.
    logic        prev_sclk = 1'b0, prev_sen = 1'b0, prev_sdi = 1'b0;
    logic [23:0] slave_val = '0;
    logic [31:0] af_word = '0, af_last = '0, op_word = '0, op_last = '0, op_prev = '0;
    logic        af_active = 1'b0, af_rd = 1'b0;
    int af_cnt = 0, af_frames = 0, af_last_cnt = 0, setup_run = 0, setup_last = 0;
    int op_cnt = 0, op_frames = 0, op_last_cnt = 0;
    int sdi_viol = 0, hi_run = 0, hi_bad = 0, oe_bad = 0;
    int low_run = 0, low_at_done = 0, sen_hi_run = 0, pulse_last = 0, done_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk && prev_sclk && sdi != prev_sdi) sdi_viol++;
            if (sclk) hi_run++;
            else if (prev_sclk) begin
                if (hi_run != HALF) hi_bad++;
                hi_run = 0;
            end
            if (sen && !prev_sen) begin
                if (op_cnt > 0) begin
                    op_prev = op_last; op_last = op_word; op_last_cnt = op_cnt;
                    op_frames++; op_cnt = 0; op_word = '0;
                end else begin
                    af_active = 1'b1; af_cnt = 0; af_word = '0; setup_run = 0;
                end
                sen_hi_run = 0;
            end
            if (!sen && prev_sen) begin
                if (af_active) begin
                    af_active = 1'b0; af_last = af_word; af_last_cnt = af_cnt; af_frames++;
                end else begin
                    pulse_last = sen_hi_run;
                end
                low_run = 0;
            end
            if (sclk && !prev_sclk) begin
                if (sen) begin
                    if (af_cnt == 0) setup_last = setup_run;
                    af_word = {af_word[30:0], sdi};
                    af_cnt++;
                    if (af_cnt == 1) af_rd = sdi;
                    if (af_rd && af_cnt >= 8) begin
                        if (sdi_oe) oe_bad++;
                        if (af_cnt <= 31) sdo = slave_val[5'(31 - af_cnt)];
                    end
                end else begin
                    op_word = {op_word[30:0], sdi};
                    op_cnt++;
                    if (op_cnt <= 24) sdo = slave_val[5'(24 - op_cnt)];
                end
            end
            if (done) begin
                low_at_done = low_run;
                done_cnt++;
            end
            if (sen) begin
                sen_hi_run++;
                if (af_active && af_cnt == 0) setup_run++;
            end else begin
                low_run++;
            end
        end
        prev_sclk = sclk; prev_sen = sen; prev_sdi = sdi;
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9 watchdog expired", 32'(busy), 32'h0);
        finish_run();
    end

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done pulse seen", 32'(done), 32'h1);
        @(negedge clk);
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        slave_val = v.sval;
        open_mode = v.open_m; rd = v.rd; reg_addr = v.addr;
        chip_addr = v.chip; wdata = v.wdata;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        chk({sen, sclk, sdi, busy, done, sdi_oe} == 6'b000001, "R1 pins in reset",
            32'({sen, sclk, sdi, busy, done, sdi_oe}), 32'h1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({sen, sclk, sdi, busy, done, sdi_oe} == 6'b000001, "R1 pins after reset",
            32'({sen, sclk, sdi, busy, done, sdi_oe}), 32'h1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int af0, op0, dn0;
            logic [23:0] rd0;
            v = VECS[i];
            af0 = af_frames; op0 = op_frames; dn0 = done_cnt; rd0 = rdata;
            issue(v);
            wait_done();
            chk(done_cnt - dn0 == 1, "R9 one done per request", 32'(done_cnt - dn0), 32'h1);
            chk(low_at_done >= RECOV, "R8 recovery before done", 32'(low_at_done), 32'(RECOV));
            if (!v.open_m) begin
                chk(af_frames - af0 == 1 && op_frames == op0, "R2 one enable-first frame",
                    32'(af_frames - af0), 32'h1);
                chk(setup_last >= SETUP, "R2 enable-to-clock setup", 32'(setup_last), 32'(SETUP));
                if (!v.rd) begin
                    chk(af_last_cnt == 32, "R3 clock count", 32'(af_last_cnt), 32'd32);
                    chk(af_last == {1'b0, v.addr, v.wdata, 1'b0}, "R3 write frame bits",
                        af_last, {1'b0, v.addr, v.wdata, 1'b0});
                    chk(rdata == rd0, "R10 rdata kept on write", 32'(rdata), 32'(rd0));
                end else begin
                    chk(af_last == {1'b1, v.addr, 25'h0}, "R2 read command and address",
                        af_last, {1'b1, v.addr, 25'h0});
                    chk(rdata == v.sval, "R4 read data", 32'(rdata), 32'(v.sval));
                end
            end else begin
                chk(af_frames == af0, "R5 no enable-first frame", 32'(af_frames - af0), 32'h0);
                chk(pulse_last >= SENHI, "R5 latch pulse width", 32'(pulse_last), 32'(SENHI));
                chk(op_last_cnt == 32, "R5 open clock count", 32'(op_last_cnt), 32'd32);
                if (!v.rd) begin
                    chk(op_frames - op0 == 1, "R5 one open frame", 32'(op_frames - op0), 32'h1);
                    chk(op_last == {v.wdata, v.addr[4:0], v.chip}, "R5 open word",
                        op_last, {v.wdata, v.addr[4:0], v.chip});
                    chk(rdata == rd0, "R10 rdata kept on open write", 32'(rdata), 32'(rd0));
                end else begin
                    chk(op_frames - op0 == 2, "R6 two open frames", 32'(op_frames - op0), 32'h2);
                    chk(op_prev == {16'h0, v.addr[4:0], 3'b000, 5'h0, v.chip},
                        "R6 pointer write word", op_prev,
                        {16'h0, v.addr[4:0], 3'b000, 5'h0, v.chip});
                    chk(op_last == 32'h0, "R6 fetch frame sends zeros", op_last, 32'h0);
                    chk(rdata == v.sval, "R6 open read data", 32'(rdata), 32'(v.sval));
                end
            end
        end

        // R9: a start while busy is ignored
        begin
            vec_t a, b;
            int af0, op0, dn0;
            a = '{1'b0, 1'b0, 6'h11, 3'h0, 24'h5A5A5A, 24'h0};
            b = '{1'b1, 1'b0, 6'h07, 3'h2, 24'h123456, 24'h0};
            af0 = af_frames; op0 = op_frames; dn0 = done_cnt;
            issue(a);
            repeat (10) @(negedge clk);
            chk(busy == 1'b1, "R9 busy during transfer", 32'(busy), 32'h1);
            issue(b);
            wait_done();
            repeat (300) @(negedge clk);
            chk(af_frames - af0 == 1, "R9 ignored start adds no frame", 32'(af_frames - af0), 32'h1);
            chk(op_frames == op0, "R9 ignored start sends no open frame",
                32'(op_frames - op0), 32'h0);
            chk(af_last == {1'b0, a.addr, a.wdata, 1'b0}, "R9 transfer unchanged",
                af_last, {1'b0, a.addr, a.wdata, 1'b0});
            chk(done_cnt - dn0 == 1, "R9 single done", 32'(done_cnt - dn0), 32'h1);
            chk(busy == 1'b0, "R9 idle afterwards", 32'(busy), 32'h0);
        end

        chk(sdi_viol == 0, "R7 sdi steady while clock high", 32'(sdi_viol), 32'h0);
        chk(hi_bad == 0, "R7 clock high phase length", 32'(hi_bad), 32'h0);
        chk(oe_bad == 0, "R4 data line released", 32'(oe_bad), 32'h0);
        finish_run();
    end
endmodule